// File: doc/BRIEF.md
# Memory Scrubber with Fixed-Priority Port Arbiter

This block keeps a protected memory in step with a golden copy. A scrub engine walks the protected memory one frame at a time in ascending order and wraps back to frame zero after the last one. In readback mode it reads each word, compares it with the matching golden word and writes the golden value back only where the two differ, counting every difference. In blind mode it rewrites every word from the golden copy without looking at the stored value, and it counts nothing.

The protected memory has a single word-wide port that three requesters share. Live image traffic always wins. The scrub engine comes second. Background traffic is served only when neither of the other two is asking. One grant covers one word access. Both memories are synchronous RAMs inside the block. The golden memory is filled through its own write port. A small control register starts or stops the walk and selects the mode, and any write to it clears the error counter. A stop request takes effect only once the current frame has finished.

Top module: `mem_scrubber`

## Requirements
- R1: After reset, `frame_idx` is 0, `err_count` is 0, `frame_done` is low, both read-valid outputs are low and the scrub engine is stopped.
- R2: Each cycle at most one requester is granted. `live_gnt` equals `live_req` in the same cycle. The scrub engine is granted only when live traffic is idle. `bg_gnt` is high only when neither live traffic nor the scrub engine requests, so a scrub walk keeps advancing while background traffic requests every cycle, and it freezes while live traffic requests every cycle.
- R3: A granted read (`*_we` = 0) presents the addressed word on `mem_rdata` one cycle later, with that requester's read-valid output high for exactly that cycle.
- R4: Frames are visited in ascending order and the walk wraps from frame NUM_FRAMES-1 to frame 0. `frame_done` pulses for one cycle as each frame completes, and in that same cycle `frame_idx` already shows the next frame. `frame_idx` changes at no other time.
- R5: Readback mode (`ctrl_blind` = 0): after one full pass over all frames, every protected word equals its golden word.
- R6: In readback mode, `err_count` rises by one for each word found different from its golden word. Blind mode never changes `err_count`.
- R7: `err_count` saturates at all ones and does not wrap.
- R8: Any cycle with `ctrl_we` = 1 sets `err_count` to 0 on the next cycle.
- R9: Blind mode (`ctrl_blind` = 1): every word is rewritten from the golden copy with no comparison, so after one full pass every protected word equals its golden word.
- R10: Writing `ctrl_run` = 0 lets the frame in progress finish, with one more `frame_done` pulse, and then stops the walk. Writing `ctrl_run` = 1 resumes the walk at word 0 of the frame shown on `frame_idx`. The mode is taken from the control register at each frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe; also clears the error counter |
| ctrl_run | input | 1 | Run bit written on `ctrl_we` |
| ctrl_blind | input | 1 | Mode bit written on `ctrl_we` (1 = blind, 0 = readback) |
| gold_we | input | 1 | Golden memory write enable |
| gold_addr | input | ADDR_W | Golden memory write address |
| gold_wdata | input | DATA_W | Golden memory write data |
| live_req | input | 1 | Live traffic access request |
| live_we | input | 1 | Live access is a write |
| live_addr | input | ADDR_W | Live access address |
| live_wdata | input | DATA_W | Live write data |
| live_gnt | output | 1 | Live access granted this cycle |
| live_rvalid | output | 1 | Live read data valid on `mem_rdata` |
| bg_req | input | 1 | Background access request |
| bg_we | input | 1 | Background access is a write |
| bg_addr | input | ADDR_W | Background access address |
| bg_wdata | input | DATA_W | Background write data |
| bg_gnt | output | 1 | Background access granted this cycle |
| bg_rvalid | output | 1 | Background read data valid on `mem_rdata` |
| mem_rdata | output | DATA_W | Registered protected memory read data |
| frame_done | output | 1 | One-cycle pulse when a frame completes |
| frame_idx | output | FIDX_W | Frame being scrubbed, or the next frame to scrub |
| err_count | output | ERR_W | Saturating count of mismatched words |

## Verification
The checks assume that a requester keeps its request and access fields steady until it is granted, and that the golden memory is not written while the walk is running. Without those assumptions a compare could use a golden word that is changing under it. The bench loads golden data and corrupts protected words only while the engine is stopped, then starts a pass. It holds live and background requests steady across each grant window. Corruption masks are always non-zero, so every injected fault is a real mismatch, and the count of injected faults gives the expected error total.

// File: rtl/mem_scrubber_pkg.sv
package mem_scrubber_pkg;

  // Scrub engine sequencing per word
  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_READ  = 2'd1,
    SC_CMP   = 2'd2,
    SC_WRITE = 2'd3
  } scrub_state_e;

  // Requester slots on the shared port, lowest index wins
  localparam int unsigned SLOT_LIVE  = 0;
  localparam int unsigned SLOT_SCRUB = 1;
  localparam int unsigned SLOT_BG    = 2;
  localparam int unsigned NUM_SLOTS  = 3;

endpackage

// File: rtl/scrub_ram.sv
// Simple dual-port synchronous RAM, registered read, written for block RAM inference.
module scrub_ram #(
  parameter int unsigned DW    = 16,
  parameter int unsigned AW    = 5,
  parameter int unsigned DEPTH = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/scrub_arb.sv
// Fixed-priority arbiter: the lowest set request bit wins.
module scrub_arb #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  assign gnt = req & (~req + N'(1));

endmodule

// File: rtl/scrub_engine.sv
// Walks frames word by word and repairs words from the golden copy.
module scrub_engine
  import mem_scrubber_pkg::*;
#(
  parameter int unsigned DW     = 16,
  parameter int unsigned NF     = 8,
  parameter int unsigned FW     = 4,
  parameter int unsigned ERR_W  = 4,
  localparam int unsigned WORD_W = $clog2(FW),
  localparam int unsigned FIDX_W = $clog2(NF),
  localparam int unsigned AW     = FIDX_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              blind,
  input  logic              clr,
  // shared port
  output logic              req,
  output logic              we,
  output logic [AW-1:0]     addr,
  output logic [DW-1:0]     wdata,
  input  logic              gnt,
  input  logic [DW-1:0]     mem_rdata,
  // golden read port
  output logic              gold_re,
  output logic [AW-1:0]     gold_raddr,
  input  logic [DW-1:0]     gold_rdata,
  // telemetry
  output logic              frame_done,
  output logic [FIDX_W-1:0] frame_idx,
  output logic [ERR_W-1:0]  err_count
);

  scrub_state_e      state_q;
  logic [WORD_W-1:0] word_q;
  logic [FIDX_W-1:0] fidx_q;
  logic              blind_q;
  logic              fdone_q;
  logic [ERR_W-1:0]  err_q;

  logic last_word, last_frame, mismatch, step, count_hit;

  assign last_word  = (word_q == WORD_W'(FW - 1));
  assign last_frame = (fidx_q == FIDX_W'(NF - 1));
  assign mismatch   = (mem_rdata != gold_rdata);

  assign addr       = {fidx_q, word_q};
  assign gold_raddr = {fidx_q, word_q};
  assign gold_re    = (state_q == SC_READ);
  assign req        = ((state_q == SC_READ) && !blind_q) || (state_q == SC_WRITE);
  assign we         = (state_q == SC_WRITE);
  assign wdata      = gold_rdata;

  assign step      = ((state_q == SC_CMP) && !blind_q && !mismatch) ||
                     ((state_q == SC_WRITE) && gnt);
  assign count_hit = (state_q == SC_CMP) && !blind_q && mismatch;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SC_IDLE;
      word_q  <= '0;
      fidx_q  <= '0;
      blind_q <= 1'b0;
      fdone_q <= 1'b0;
      err_q   <= '0;
    end else begin
      fdone_q <= 1'b0;

      if (clr)
        err_q <= '0;
      else if (count_hit && (err_q != '1))
        err_q <= err_q + ERR_W'(1);

      case (state_q)
        SC_IDLE: if (run) begin
          blind_q <= blind;
          word_q  <= '0;
          state_q <= SC_READ;
        end
        SC_READ: if (blind_q || gnt) state_q <= SC_CMP;
        SC_CMP:  if (blind_q || mismatch) state_q <= SC_WRITE;
        default: ;
      endcase

      if (step) begin
        if (last_word) begin
          word_q  <= '0;
          fdone_q <= 1'b1;
          fidx_q  <= last_frame ? '0 : fidx_q + FIDX_W'(1);
          blind_q <= blind;
          state_q <= run ? SC_READ : SC_IDLE;
        end else begin
          word_q  <= word_q + WORD_W'(1);
          state_q <= SC_READ;
        end
      end
    end
  end

  assign frame_done = fdone_q;
  assign frame_idx  = fidx_q;
  assign err_count  = err_q;

endmodule

// File: rtl/mem_scrubber.sv
// Protected memory, golden memory, scrub engine and three-way port arbiter.
// FRAME_WORDS and NUM_FRAMES must be powers of two, each at least 2.
module mem_scrubber
  import mem_scrubber_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned NUM_FRAMES  = 8,
  parameter int unsigned FRAME_WORDS = 4,
  parameter int unsigned ERR_W       = 4,
  localparam int unsigned FIDX_W = $clog2(NUM_FRAMES),
  localparam int unsigned ADDR_W = FIDX_W + $clog2(FRAME_WORDS),
  localparam int unsigned DEPTH  = NUM_FRAMES * FRAME_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic              ctrl_run,
  input  logic              ctrl_blind,
  input  logic              gold_we,
  input  logic [ADDR_W-1:0] gold_addr,
  input  logic [DATA_W-1:0] gold_wdata,
  input  logic              live_req,
  input  logic              live_we,
  input  logic [ADDR_W-1:0] live_addr,
  input  logic [DATA_W-1:0] live_wdata,
  output logic              live_gnt,
  output logic              live_rvalid,
  input  logic              bg_req,
  input  logic              bg_we,
  input  logic [ADDR_W-1:0] bg_addr,
  input  logic [DATA_W-1:0] bg_wdata,
  output logic              bg_gnt,
  output logic              bg_rvalid,
  output logic [DATA_W-1:0] mem_rdata,
  output logic              frame_done,
  output logic [FIDX_W-1:0] frame_idx,
  output logic [ERR_W-1:0]  err_count
);

  logic run_q, blind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      blind_q <= 1'b0;
    end else if (ctrl_we) begin
      run_q   <= ctrl_run;
      blind_q <= ctrl_blind;
    end
  end

  // Scrub engine
  logic              scr_req, scr_we, scr_gnt;
  logic [ADDR_W-1:0] scr_addr;
  logic [DATA_W-1:0] scr_wdata;
  logic              gold_re;
  logic [ADDR_W-1:0] gold_raddr;
  logic [DATA_W-1:0] gold_rdata;

  scrub_engine #(
    .DW(DATA_W), .NF(NUM_FRAMES), .FW(FRAME_WORDS), .ERR_W(ERR_W)
  ) u_engine (
    .clk(clk), .rst(rst), .run(run_q), .blind(blind_q), .clr(ctrl_we),
    .req(scr_req), .we(scr_we), .addr(scr_addr), .wdata(scr_wdata),
    .gnt(scr_gnt), .mem_rdata(mem_rdata),
    .gold_re(gold_re), .gold_raddr(gold_raddr), .gold_rdata(gold_rdata),
    .frame_done(frame_done), .frame_idx(frame_idx), .err_count(err_count)
  );

  // Arbitration
  logic [NUM_SLOTS-1:0] req_vec, gnt_vec;

  always_comb begin
    req_vec             = '0;
    req_vec[SLOT_LIVE]  = live_req;
    req_vec[SLOT_SCRUB] = scr_req;
    req_vec[SLOT_BG]    = bg_req;
  end

  scrub_arb #(.N(NUM_SLOTS)) u_arb (.req(req_vec), .gnt(gnt_vec));

  assign live_gnt = gnt_vec[SLOT_LIVE];
  assign scr_gnt  = gnt_vec[SLOT_SCRUB];
  assign bg_gnt   = gnt_vec[SLOT_BG];

  // Access mux onto the single protected port
  logic              acc_en, acc_we;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata;

  always_comb begin
    acc_en    = |gnt_vec;
    acc_we    = 1'b0;
    acc_addr  = '0;
    acc_wdata = '0;
    if (live_gnt) begin
      acc_we = live_we; acc_addr = live_addr; acc_wdata = live_wdata;
    end else if (scr_gnt) begin
      acc_we = scr_we;  acc_addr = scr_addr;  acc_wdata = scr_wdata;
    end else if (bg_gnt) begin
      acc_we = bg_we;   acc_addr = bg_addr;   acc_wdata = bg_wdata;
    end
  end

  scrub_ram #(.DW(DATA_W), .AW(ADDR_W), .DEPTH(DEPTH)) u_prot (
    .clk(clk), .we(acc_en & acc_we), .waddr(acc_addr), .wdata(acc_wdata),
    .re(acc_en & ~acc_we), .raddr(acc_addr), .rdata(mem_rdata)
  );

  scrub_ram #(.DW(DATA_W), .AW(ADDR_W), .DEPTH(DEPTH)) u_gold (
    .clk(clk), .we(gold_we), .waddr(gold_addr), .wdata(gold_wdata),
    .re(gold_re), .raddr(gold_raddr), .rdata(gold_rdata)
  );

  // Read-valid flags
  logic live_rv_q, bg_rv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_rv_q <= 1'b0;
      bg_rv_q   <= 1'b0;
    end else begin
      live_rv_q <= live_gnt & ~live_we;
      bg_rv_q   <= bg_gnt & ~bg_we;
    end
  end

  assign live_rvalid = live_rv_q;
  assign bg_rvalid   = bg_rv_q;

endmodule

// File: rtl/mem_scrubber_chk.sv
module mem_scrubber_chk #(
  parameter int unsigned NF     = 8,
  parameter int unsigned FIDX_W = 3,
  parameter int unsigned ERR_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ctrl_we,
  input logic              live_req,
  input logic              live_we,
  input logic              live_gnt,
  input logic              live_rvalid,
  input logic              bg_req,
  input logic              bg_we,
  input logic              bg_gnt,
  input logic              bg_rvalid,
  input logic              scr_req,
  input logic              scr_gnt,
  input logic              frame_done,
  input logic [FIDX_W-1:0] frame_idx,
  input logic [ERR_W-1:0]  err_count
);

  p_live_wins_r2: assert property (@(posedge clk) disable iff (rst)
    live_req |-> (live_gnt && !scr_gnt && !bg_gnt));

  p_scrub_over_bg_r2: assert property (@(posedge clk) disable iff (rst)
    (scr_req && !live_req) |-> (scr_gnt && !bg_gnt));

  p_bg_when_free_r2: assert property (@(posedge clk) disable iff (rst)
    (bg_req && !live_req && !scr_req) |-> bg_gnt);

  p_one_grant_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({live_gnt, scr_gnt, bg_gnt}));

  p_live_rvalid_r3: assert property (@(posedge clk) disable iff (rst)
    (live_gnt && !live_we) |=> live_rvalid);

  p_bg_rvalid_r3: assert property (@(posedge clk) disable iff (rst)
    (bg_gnt && !bg_we) |=> bg_rvalid);

  p_fidx_step_r4: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (frame_idx == (($past(frame_idx) == FIDX_W'(NF - 1)) ?
                                  FIDX_W'(0) : $past(frame_idx) + FIDX_W'(1))));

  p_fidx_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !frame_done |-> $stable(frame_idx));

  p_no_decrease_r6: assert property (@(posedge clk) disable iff (rst)
    !ctrl_we |=> (err_count >= $past(err_count)));

  p_saturate_r7: assert property (@(posedge clk) disable iff (rst)
    ((err_count == '1) && !ctrl_we) |=> (err_count == '1));

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    ctrl_we |=> (err_count == '0));

endmodule

bind mem_scrubber mem_scrubber_chk #(
  .NF(NUM_FRAMES), .FIDX_W(FIDX_W), .ERR_W(ERR_W)
) u_chk (
  .clk(clk), .rst(rst), .ctrl_we(ctrl_we),
  .live_req(live_req), .live_we(live_we), .live_gnt(live_gnt), .live_rvalid(live_rvalid),
  .bg_req(bg_req), .bg_we(bg_we), .bg_gnt(bg_gnt), .bg_rvalid(bg_rvalid),
  .scr_req(scr_req), .scr_gnt(scr_gnt),
  .frame_done(frame_done), .frame_idx(frame_idx), .err_count(err_count)
);

// File: tb/tb_mem_scrubber.sv
`timescale 1ns/1ps
module tb_mem_scrubber;

  localparam int DW = 16;
  localparam int NF = 8;
  localparam int FW = 4;
  localparam int EW = 4;
  localparam int FIW = $clog2(NF);
  localparam int AW = FIW + $clog2(FW);
  localparam int DEPTH = NF * FW;
  localparam int ERR_MAX = (1 << EW) - 1;

  logic clk = 1'b0;
  logic rst;
  logic ctrl_we, ctrl_run, ctrl_blind;
  logic gold_we;
  logic [AW-1:0] gold_addr;
  logic [DW-1:0] gold_wdata;
  logic live_req, live_we;
  logic [AW-1:0] live_addr;
  logic [DW-1:0] live_wdata;
  logic live_gnt, live_rvalid;
  logic bg_req, bg_we;
  logic [AW-1:0] bg_addr;
  logic [DW-1:0] bg_wdata;
  logic bg_gnt, bg_rvalid;
  logic [DW-1:0] mem_rdata;
  logic frame_done;
  logic [FIW-1:0] frame_idx;
  logic [EW-1:0] err_count;

  always #2.5 clk = ~clk;

  mem_scrubber #(.DATA_W(DW), .NUM_FRAMES(NF), .FRAME_WORDS(FW), .ERR_W(EW)) dut (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_run(ctrl_run), .ctrl_blind(ctrl_blind),
    .gold_we(gold_we), .gold_addr(gold_addr), .gold_wdata(gold_wdata),
    .live_req(live_req), .live_we(live_we), .live_addr(live_addr), .live_wdata(live_wdata),
    .live_gnt(live_gnt), .live_rvalid(live_rvalid),
    .bg_req(bg_req), .bg_we(bg_we), .bg_addr(bg_addr), .bg_wdata(bg_wdata),
    .bg_gnt(bg_gnt), .bg_rvalid(bg_rvalid), .mem_rdata(mem_rdata),
    .frame_done(frame_done), .frame_idx(frame_idx), .err_count(err_count)
  );

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;
  int fd_cnt = 0;
  int last_fidx = 0;
  logic [DW-1:0] gold_m [DEPTH];
  bit hit [DEPTH];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int next_frame(input int f);
    return (f == NF - 1) ? 0 : f + 1;
  endfunction

  function automatic int expect_err(input int k);
    return (k > ERR_MAX) ? ERR_MAX : k;
  endfunction

  // frame_done monitor: ordered walk with wrap (R4)
  always @(negedge clk) begin
    if (!rst && frame_done) begin
      fd_cnt++;
      check(int'(frame_idx) == next_frame(last_fidx), "R4", "frame order",
            int'(frame_idx), next_frame(last_fidx));
      last_fidx = int'(frame_idx);
    end
  end

  task automatic ctrl_write(input logic run, input logic blind);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_run = run; ctrl_blind = blind;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic gold_write(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    gold_we = 1'b1; gold_addr = AW'(a); gold_wdata = d;
    @(negedge clk);
    gold_we = 1'b0;
  endtask

  task automatic bg_access(input logic we, input int a, input logic [DW-1:0] d,
                           output logic [DW-1:0] rd);
    @(negedge clk);
    bg_req = 1'b1; bg_we = we; bg_addr = AW'(a); bg_wdata = d;
    #1;
    while (!bg_gnt) begin @(negedge clk); #1; end
    @(negedge clk);
    rd = mem_rdata;
    if (!we) check(bg_rvalid == 1'b1, "R3", "bg read valid", int'(bg_rvalid), 1);
    bg_req = 1'b0; bg_we = 1'b0;
  endtask

  task automatic corrupt(input int k);
    logic [DW-1:0] dummy;
    for (int i = 0; i < DEPTH; i++) hit[i] = 1'b0;
    for (int i = 0; i < k; i++) begin
      int a;
      logic [DW-1:0] mask;
      a = int'($urandom % DEPTH);
      while (hit[a]) a = int'($urandom % DEPTH);
      hit[a] = 1'b1;
      mask = DW'(($urandom % 65535) + 1);
      bg_access(1'b1, a, gold_m[a] ^ mask, dummy);
    end
  endtask

  // One full pass, stop, then verify contents against the golden model.
  task automatic full_pass(input logic blind, input int exp_err, input string req);
    int start_fd, start_f, stop_fd;
    logic [DW-1:0] rd;
    start_fd = fd_cnt;
    start_f  = int'(frame_idx);
    ctrl_write(1'b1, blind);
    while (fd_cnt < start_fd + NF) @(negedge clk);
    check(int'(frame_idx) == start_f, "R4", "wrap back to start frame", int'(frame_idx), start_f);
    if (blind) check(int'(err_count) == 0, "R6", "blind count", int'(err_count), 0);
    else if (exp_err == ERR_MAX)
      check(int'(err_count) == exp_err, "R7", "saturated count", int'(err_count), exp_err);
    else
      check(int'(err_count) == exp_err, "R6", "readback count", int'(err_count), exp_err);
    ctrl_write(1'b0, blind);
    check(int'(err_count) == 0, "R8", "clear on control write", int'(err_count), 0);
    stop_fd = fd_cnt;
    while (fd_cnt < stop_fd + 1) @(negedge clk);
    stop_fd = fd_cnt;
    repeat (30) @(negedge clk);
    check(fd_cnt == stop_fd, "R10", "no frame after stop", fd_cnt, stop_fd);
    check(int'(frame_idx) == next_frame(start_f), "R10", "stopped frame",
          int'(frame_idx), next_frame(start_f));
    for (int a = 0; a < DEPTH; a++) begin
      bg_access(1'b0, a, '0, rd);
      check(rd == gold_m[a], req, "word repaired", int'(rd), int'(gold_m[a]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    int fd0, f0, bg_hits;
    void'($urandom(32'd1879));
    rst = 1'b1;
    ctrl_we = 0; ctrl_run = 0; ctrl_blind = 0;
    gold_we = 0; gold_addr = '0; gold_wdata = '0;
    live_req = 0; live_we = 0; live_addr = '0; live_wdata = '0;
    bg_req = 0; bg_we = 0; bg_addr = '0; bg_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(frame_idx == '0, "R1", "frame_idx", int'(frame_idx), 0);
    check(err_count == '0, "R1", "err_count", int'(err_count), 0);
    check(frame_done == 1'b0, "R1", "frame_done", int'(frame_done), 0);
    check(live_rvalid == 1'b0 && bg_rvalid == 1'b0, "R1", "rvalid",
          int'(live_rvalid) + int'(bg_rvalid), 0);
    repeat (10) @(negedge clk);
    check(fd_cnt == 0, "R1", "engine stopped", fd_cnt, 0);

    // Load golden and protected memories
    for (int a = 0; a < DEPTH; a++) begin
      gold_m[a] = DW'($urandom);
      gold_write(a, gold_m[a]);
      bg_access(1'b1, a, gold_m[a], rd);
    end

    // R5 readback repair, R6 count
    corrupt(5);
    full_pass(1'b0, expect_err(5), "R5");

    // R7 saturation
    corrupt(20);
    full_pass(1'b0, expect_err(20), "R5");

    // R9 blind rewrite, no counting
    corrupt(7);
    full_pass(1'b1, 0, "R9");

    // R2/R3: live priority and data, scrub frozen, bg starved
    ctrl_write(1'b1, 1'b0);
    repeat (5) @(negedge clk);
    fd0 = 0; f0 = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check(live_rvalid == 1'b1, "R3", "live read valid", int'(live_rvalid), 1);
        check(mem_rdata == gold_m[(i - 1) % DEPTH], "R3", "live read data",
              int'(mem_rdata), int'(gold_m[(i - 1) % DEPTH]));
      end
      live_req = 1'b1; live_we = 1'b0; live_addr = AW'(i % DEPTH);
      bg_req = 1'b1; bg_we = 1'b0; bg_addr = '0;
      #1;
      check(live_gnt == 1'b1, "R2", "live granted", int'(live_gnt), 1);
      check(bg_gnt == 1'b0, "R2", "bg blocked by live", int'(bg_gnt), 0);
      if (i == 3) begin fd0 = fd_cnt; f0 = int'(frame_idx); end
    end
    check(fd_cnt == fd0, "R2", "scrub frozen under live", fd_cnt, fd0);
    check(int'(frame_idx) == f0, "R2", "frame held under live", int'(frame_idx), f0);
    @(negedge clk);
    live_req = 1'b0;
    fd0 = fd_cnt;
    bg_hits = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      #1;
      if (bg_gnt) bg_hits++;
    end
    check(fd_cnt > fd0, "R2", "scrub advances over bg", fd_cnt - fd0, fd0 + 1);
    check(bg_hits > 0, "R2", "bg served in free cycles", bg_hits, 1);
    @(negedge clk);
    bg_req = 1'b0;
    ctrl_write(1'b0, 1'b0);
    fd0 = fd_cnt;
    while (fd_cnt < fd0 + 1) @(negedge clk);
    repeat (20) @(negedge clk);

    // R10 resume from the stopped frame, readback once more
    corrupt(3);
    full_pass(1'b0, 3, "R5");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule